// File: doc/BRIEF.md
# Boot-Overlay Memory Chip-Select Decoder

This block drives the two active-low chip enables of an 8-bit CPU system whose 64 KB memory space is split evenly. A 32 KB RAM fills the lower half and a 32 KB ROM fills the upper half, and the top address bit picks between them whenever the CPU requests a memory cycle. I/O cycles live in their own address space and never enable either memory. The read and write strobes go straight to the memories and do not pass through this block.

Execution starts at address zero after reset, which falls in the RAM half. A sticky boot-overlay flag covers this case. Reset sets the flag, and while it is set the decoder treats the top address bit as high, so every memory access selects ROM. The first qualified I/O cycle clears the flag: I/O request low with M1 high. From then on RAM is visible at the low addresses, so software can rewrite the restart vectors there. Only another reset sets the flag again. An interrupt-acknowledge cycle also asserts I/O request, but it does so with M1 low, so it leaves the flag unchanged.

Top module: `boot_ovl_cs`

## Requirements
- R1: While the overlay flag is set (from reset until the first qualified I/O cycle), a memory request (mreq_n low) drives rom_ce_n low and keeps ram_ce_n high for either value of addr_hi.
- R2: With the flag clear, mreq_n low and addr_hi low drive ram_ce_n low and keep rom_ce_n high.
- R3: With the flag clear, mreq_n low and addr_hi high drive rom_ce_n low and keep ram_ce_n high.
- R4: When mreq_n is high, both ram_ce_n and rom_ce_n are high, including during I/O cycles.
- R5: ram_ce_n and rom_ce_n are never low together.
- R6: The flag clears at the first rising clock edge at which iorq_n is low and m1_n is high. A memory access in the cycle before that edge still selects ROM. Any access after that edge with addr_hi low selects RAM.
- R7: iorq_n low together with m1_n low (interrupt acknowledge) does not clear the flag.
- R8: Once the flag is clear, it stays clear until rst_n is asserted. Asserting rst_n (low, asynchronous) sets it again at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock; the overlay flag updates on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; sets the overlay flag |
| mreq_n | input | 1 | Active-low memory request |
| iorq_n | input | 1 | Active-low I/O request |
| m1_n | input | 1 | Active-low M1 (opcode fetch / interrupt acknowledge) |
| addr_hi | input | 1 | Top address bit (A15) |
| ram_ce_n | output | 1 | Active-low RAM chip enable |
| rom_ce_n | output | 1 | Active-low ROM chip enable |

## Verification
The embedded assertions check four properties on every clock. The two enables are never asserted together. With no memory request, both enables stay off. While the flag is set, every memory request goes to ROM. The flag clears after a qualified I/O cycle, holds through an interrupt acknowledge, and stays clear once cleared. Only the bench scenarios can show the behaviour over a whole sequence. A fetch from address zero after reset reaches ROM. The same address reaches RAM once an I/O cycle has passed. A memory access that shares its cycle with the clearing I/O cycle still goes to ROM, and a reset in the middle of a run brings the overlay back.

// File: rtl/boot_ovl_pkg.sv
package boot_ovl_pkg;

    // Registered state of the boot-overlay tracker
    typedef struct packed {
        logic boot;
    } ovl_state_t;

    // Which memory device a cycle targets
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_RAM  = 2'd1,
        TGT_ROM  = 2'd2
    } mem_tgt_e;

    // Chip-enable pair, active low
    typedef struct packed {
        logic ram_n;
        logic rom_n;
    } ce_pair_t;

endpackage

// File: rtl/boot_ovl_flag.sv
module boot_ovl_flag
    import boot_ovl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic iorq_n,
    input  logic m1_n,
    output logic boot_o
);

    ovl_state_t st_d;
    ovl_state_t st_q;
    logic       io_cycle;

    // A real I/O cycle: I/O request with M1 inactive (not an interrupt acknowledge)
    assign io_cycle = !iorq_n && m1_n;

    always_comb begin
        st_d = st_q;
        if (io_cycle) begin
            st_d.boot = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{boot: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign boot_o = st_q.boot;

    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!iorq_n && m1_n) |=> !boot_o); // R6
    AST_ACK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_o && !(!iorq_n && m1_n)) |=> boot_o); // R7
    AST_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_o |=> !boot_o); // R8

endmodule

// File: rtl/boot_ovl_decode.sv
module boot_ovl_decode
    import boot_ovl_pkg::*;
(
    input  logic mreq_n,
    input  logic addr_hi,
    input  logic boot,
    output logic ram_ce_n,
    output logic rom_ce_n
);

    mem_tgt_e tgt_d;
    ce_pair_t ce_d;
    logic     hi_eff;

    always_comb begin
        // Overlay forces the upper-half decode
        hi_eff = addr_hi || boot;
        if (mreq_n) begin
            tgt_d = TGT_NONE;
        end else if (hi_eff) begin
            tgt_d = TGT_ROM;
        end else begin
            tgt_d = TGT_RAM;
        end

        ce_d = '{ram_n: 1'b1, rom_n: 1'b1};
        case (tgt_d)
            TGT_RAM: ce_d.ram_n = 1'b0;
            TGT_ROM: ce_d.rom_n = 1'b0;
            default: ce_d = '{ram_n: 1'b1, rom_n: 1'b1};
        endcase
    end

    assign ram_ce_n = ce_d.ram_n;
    assign rom_ce_n = ce_d.rom_n;

endmodule

// File: rtl/boot_ovl_cs.sv
module boot_ovl_cs
    import boot_ovl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mreq_n,
    input  logic iorq_n,
    input  logic m1_n,
    input  logic addr_hi,
    output logic ram_ce_n,
    output logic rom_ce_n
);

    logic boot_q;

    boot_ovl_flag flag_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .iorq_n (iorq_n),
        .m1_n   (m1_n),
        .boot_o (boot_q)
    );

    boot_ovl_decode dec_i (
        .mreq_n   (mreq_n),
        .addr_hi  (addr_hi),
        .boot     (boot_q),
        .ram_ce_n (ram_ce_n),
        .rom_ce_n (rom_ce_n)
    );

    AST_CE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ram_ce_n && !rom_ce_n)); // R5
    AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_n |-> (ram_ce_n && rom_ce_n)); // R4
    AST_BOOT_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_q && !mreq_n) |-> (!rom_ce_n && ram_ce_n)); // R1

endmodule

// File: tb/boot_ovl_cs_tb.sv
module boot_ovl_cs_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mreq_n = 1'b1;
    logic iorq_n = 1'b1;
    logic m1_n = 1'b1;
    logic addr_hi = 1'b0;
    logic ram_ce_n;
    logic rom_ce_n;

    int checks = 0;
    int errors = 0;
    bit exp_boot = 1'b1;
    bit done = 1'b0;

    always #2 clk = ~clk;

    boot_ovl_cs dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mreq_n   (mreq_n),
        .iorq_n   (iorq_n),
        .m1_n     (m1_n),
        .addr_hi  (addr_hi),
        .ram_ce_n (ram_ce_n),
        .rom_ce_n (rom_ce_n)
    );

    // Expected {ram_ce_n, rom_ce_n} from the requirements
    function automatic logic [1:0] exp_ce(input logic mq_n, input logic a15, input bit bt);
        if (mq_n) return 2'b11;          // R4
        if (bt || a15) return 2'b10;     // R1, R3
        return 2'b01;                    // R2
    endfunction

    task automatic check(input string req);
        logic [1:0] e;
        e = exp_ce(mreq_n, addr_hi, exp_boot);
        checks++;
        if ({ram_ce_n, rom_ce_n} !== e) begin
            errors++;
            $display("FAIL %s: ram/rom = %b expected %b", req, {ram_ce_n, rom_ce_n}, e);
        end
    endtask

    // Drive one cycle at the falling edge, check, then advance past the rising edge
    task automatic cyc(input logic mq, input logic io, input logic m1, input logic a15,
                       input string req);
        @(negedge clk);
        mreq_n = mq; iorq_n = io; m1_n = m1; addr_hi = a15;
        #1;
        check(req);
        @(posedge clk);
        if (rst_n) begin
            if (!io && m1) exp_boot = 1'b0;
        end else begin
            exp_boot = 1'b1;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; mreq_n = 1'b1; iorq_n = 1'b1; m1_n = 1'b1;
        exp_boot = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // reset state: idle
        #1; check("R4 reset idle");
        do_reset();

        // R1: fetch from address 0 after reset goes to ROM
        cyc(1'b0, 1'b1, 1'b0, 1'b0, "R1 fetch addr 0");
        cyc(1'b0, 1'b1, 1'b1, 1'b0, "R1 read low half");
        cyc(1'b0, 1'b1, 1'b1, 1'b1, "R1 read high half");
        // R7: interrupt acknowledge keeps the overlay
        cyc(1'b1, 1'b0, 1'b0, 1'b0, "R7 int ack idle");
        cyc(1'b0, 1'b1, 1'b1, 1'b0, "R7 still ROM after ack");
        // R6: memory access in the same cycle as the clearing I/O still ROM
        cyc(1'b0, 1'b0, 1'b1, 1'b0, "R6 same-cycle ROM");
        // R6/R2: afterwards address 0 selects RAM
        cyc(1'b0, 1'b1, 1'b0, 1'b0, "R6 R2 addr 0 to RAM");
        cyc(1'b0, 1'b1, 1'b1, 1'b1, "R3 high half ROM");
        cyc(1'b1, 1'b0, 1'b1, 1'b0, "R4 I/O cycle idle");
        // R8: stays clear through more cycles
        cyc(1'b1, 1'b0, 1'b0, 1'b1, "R8 ack after clear");
        cyc(1'b0, 1'b1, 1'b1, 1'b0, "R8 still RAM");
        // R8: reset re-arms the overlay
        do_reset();
        cyc(1'b0, 1'b1, 1'b0, 1'b0, "R8 overlay re-armed");

        // Constrained random with occasional resets
        for (int i = 0; i < 2000; i++) begin
            logic mq, io, m1, a;
            if (($urandom % 97) == 0) begin
                do_reset();
            end
            mq = ($urandom % 4) != 0;
            mq = !mq ? 1'b0 : 1'b1;
            mq = ($urandom % 3) == 0;
            io = ($urandom % 12) != 0;
            if (!mq) io = 1'b1;
            m1 = ($urandom % 3) != 0;
            a  = ($urandom % 2) != 0;
            cyc(mq, io, m1, a, "R1 R2 R3 R4 R5 R6 R7 random");
            checks++;
            if (!ram_ce_n && !rom_ce_n) begin
                errors++;
                $display("FAIL R5: both enables low, expected at most one");
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule